// File: doc/BRIEF.md
# Polled Byte Handshake Master

This block is the host side of the byte handshake with a disk controller's command and result port. A local client hands it one request: a command string of up to `MAX_CMD` bytes to send, followed by up to `MAX_RES` result bytes to fetch. The block moves the bytes one at a time over a simple register bus that is addressed by offset. Before each data-port access it polls the controller's main status register. It waits until the controller shows the ready flag together with the direction that the next byte needs.

Status polls are spaced by a fixed interval, `SPACING_US` microseconds. The interval is turned into clock cycles from `CLK_HZ`. A byte may use at most `MAX_POLLS` polls. If the last of these polls still fails, the block abandons the whole request and does not touch the data port again. It then reads a five-register debug snapshot and raises an error pulse that carries the index of the failing byte. A request that completes ends with a done pulse. Each fetched result byte is handed out with a one-cycle valid strobe.

The controller runs through these states:
- `ST_IDLE` waits for a request.
- `ST_POLL` reads the status register.
- `ST_WAIT` counts out the poll spacing.
- `ST_XFER` performs the data-port access.
- `ST_SNAP` reads the debug registers.
- `ST_FINISH` pulses done.
- `ST_FAIL` pulses error.

The transitions between them are:
- accept: `ST_IDLE` to `ST_POLL`, or to `ST_FINISH` when the request is empty.
- poll ok: `ST_POLL` to `ST_XFER`.
- poll retry: `ST_POLL` to `ST_WAIT`.
- timeout: `ST_POLL` to `ST_SNAP`.
- pace expired: `ST_WAIT` to `ST_POLL`.
- next byte: `ST_XFER` to `ST_POLL`.
- last byte: `ST_XFER` to `ST_FINISH`.
- snapshot end: `ST_SNAP` to `ST_FAIL`.
- `ST_FINISH` and `ST_FAIL` both return to `ST_IDLE`.

Top module: `fdh_xfer_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rx_valid`, `bus_rd` and `bus_wr` are all low. No bus access happens while the block is idle.
- R2: The status register sits at offset 4 and the data port at offset 5. A byte is written to offset 5 only in the cycle right after a status read that returned bit 7 (ready) = 1 and bit 6 (direction) = 0, meaning host-to-controller.
- R3: A result byte is read from offset 5 only in the cycle right after a status read that returned bit 7 = 1 and bit 6 = 1, meaning controller-to-host. The byte read appears on `rx_byte` with `rx_valid` high in the following cycle.
- R4: Consecutive status polls for the same byte are exactly `CLK_HZ/1_000_000*SPACING_US` cycles apart. With the default parameters this is 50 cycles.
- R5: At most `MAX_POLLS` (default 5) status polls are made for one byte. After the last poll fails, no data-port access follows.
- R6: The command bytes are taken from `req_cmd_bytes`, with byte i at bits [8i+7:8i]. All `req_cmd_len` of them are sent in order, and then `req_res_len` result bytes are read. `done` pulses in the cycle after the last data-port access.
- R7: The first byte that times out aborts the request, and no later byte is sent or read. `fail_idx` gives the index of the failed byte, counting the command bytes from 0 and then the result bytes.
- R8: After a timeout, offsets 0, 1, 2, 4 and 7 are read in that order. They are stored in bytes 0 to 4 of `dbg_snap`, and then `err` pulses for one cycle.
- R9: `busy` is high from the cycle after a request is accepted up to and including the `done` or `err` cycle. It is low afterwards. `req_start` has no effect while `busy` is high, and `done` and `err` never pulse together.
- R10: A request with both lengths at zero produces a `done` pulse without any bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_cmd_len | input | $clog2(MAX_CMD+1) | Number of command bytes |
| req_res_len | input | $clog2(MAX_RES+1) | Number of result bytes |
| req_cmd_bytes | input | MAX_CMD*8 | Command bytes, byte i at [8i+7:8i] |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle timeout pulse |
| fail_idx | output | $clog2(MAX_CMD+MAX_RES+1) | Index of the byte that timed out |
| rx_valid | output | 1 | Result byte strobe |
| rx_byte | output | 8 | Result byte |
| dbg_snap | output | 40 | Debug snapshot after a timeout |
| bus_addr | output | 3 | Register offset |
| bus_rd | output | 1 | Read strobe, data returned the same cycle |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |

## Verification
A wrong state or counter in this block shows up directly on the bus. A pace counter that is off by one moves the next status read by a cycle, and this is visible at the second poll of any stalled byte. A wrong retry count adds a sixth poll, or skips the snapshot reads that should follow the fifth poll. A wrong byte index or direction choice gives a wrong or misplaced data-port byte within one access of the fault, or a `fail_idx` that does not match. The controller model stalls each byte with a mix of not-ready and wrong-direction status values, so a check of only one of the two flags is also caught at the first such poll.

// File: rtl/fdh_pkg.sv
package fdh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_WAIT,
        ST_XFER,
        ST_SNAP,
        ST_FINISH,
        ST_FAIL
    } fdh_state_e;

    // register offsets the controller decodes
    localparam logic [2:0] OFS_STAT_A = 3'd0;
    localparam logic [2:0] OFS_STAT_B = 3'd1;
    localparam logic [2:0] OFS_DOUT   = 3'd2;
    localparam logic [2:0] OFS_MAIN   = 3'd4;
    localparam logic [2:0] OFS_DATA   = 3'd5;
    localparam logic [2:0] OFS_DIN    = 3'd7;

    // main status bit positions
    localparam int MS_READY_BIT = 7;
    localparam int MS_DIR_BIT   = 6;

    localparam int SNAP_N = 5;

    function automatic logic [2:0] snap_offset(input logic [2:0] slot);
        logic [2:0] ofs;
        case (slot)
            3'd0:    ofs = OFS_STAT_A;
            3'd1:    ofs = OFS_STAT_B;
            3'd2:    ofs = OFS_DOUT;
            3'd3:    ofs = OFS_MAIN;
            default: ofs = OFS_DIN;
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/fdh_status_eval.sv
module fdh_status_eval
    import fdh_pkg::*;
(
    input  logic [7:0] status,
    input  logic       want_get,
    output logic       ok
);
    assign ok = status[MS_READY_BIT] && (status[MS_DIR_BIT] == want_get);
endmodule

// File: rtl/fdh_pacer.sv
module fdh_pacer #(
    parameter int PERIOD = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fdh_retry_ctr.sv
module fdh_retry_ctr #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/fdh_xfer_master.sv
module fdh_xfer_master
    import fdh_pkg::*;
#(
    parameter int CLK_HZ     = 1_000_000,
    parameter int SPACING_US = 50,
    parameter int MAX_POLLS  = 5,
    parameter int MAX_CMD    = 9,
    parameter int MAX_RES    = 7,
    localparam int CLW       = $clog2(MAX_CMD + 1),
    localparam int RLW       = $clog2(MAX_RES + 1),
    localparam int IW        = $clog2(MAX_CMD + MAX_RES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_start,
    input  logic [CLW-1:0]       req_cmd_len,
    input  logic [RLW-1:0]       req_res_len,
    input  logic [MAX_CMD*8-1:0] req_cmd_bytes,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [IW-1:0]        fail_idx,
    output logic                 rx_valid,
    output logic [7:0]           rx_byte,
    output logic [SNAP_N*8-1:0]  dbg_snap,
    output logic [2:0]           bus_addr,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic [7:0]           bus_wdata,
    input  logic [7:0]           bus_rdata
);
    localparam int SPACING_CYC = CLK_HZ / 1_000_000 * SPACING_US;

    fdh_state_e           state_q, state_d;
    logic [MAX_CMD*8-1:0] cmd_q;
    logic [CLW-1:0]       cmd_len_q;
    logic [IW-1:0]        total_q, idx_q;
    logic [2:0]           snap_i_q;
    logic [SNAP_N*8-1:0]  snap_q;
    logic                 rx_valid_q;
    logic [7:0]           rx_byte_q;

    logic          accept, want_get, poll_ok, tries_last, pace_done;
    logic [IW-1:0] req_total;
    logic [7:0]    tx_sel;

    assign req_total = IW'(req_cmd_len) + IW'(req_res_len);
    assign accept    = (state_q == ST_IDLE) && req_start;
    assign want_get  = (idx_q >= IW'(cmd_len_q));

    fdh_status_eval u_eval (
        .status   (bus_rdata),
        .want_get (want_get),
        .ok       (poll_ok)
    );

    fdh_retry_ctr #(.LIMIT(MAX_POLLS)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept || (state_q == ST_XFER)),
        .inc   ((state_q == ST_POLL) && !poll_ok),
        .last  (tries_last)
    );

    fdh_pacer #(.PERIOD(SPACING_CYC)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state_q == ST_POLL) && !poll_ok && !tries_last),
        .expired (pace_done)
    );

    // pick the command byte for the current index
    always_comb begin
        tx_sel = '0;
        for (int i = 0; i < MAX_CMD; i++) begin
            if (idx_q == IW'(i)) tx_sel = cmd_q[i*8 +: 8];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) state_d = (req_total == '0) ? ST_FINISH : ST_POLL;
            end
            ST_POLL: begin
                if (poll_ok)         state_d = ST_XFER;
                else if (tries_last) state_d = ST_SNAP;
                else                 state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (pace_done) state_d = ST_POLL;
            end
            ST_XFER: begin
                state_d = (idx_q == total_q - 1'b1) ? ST_FINISH : ST_POLL;
            end
            ST_SNAP: begin
                if (snap_i_q == 3'(SNAP_N - 1)) state_d = ST_FAIL;
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cmd_q      <= '0;
            cmd_len_q  <= '0;
            total_q    <= '0;
            idx_q      <= '0;
            snap_i_q   <= '0;
            snap_q     <= '0;
            rx_valid_q <= 1'b0;
            rx_byte_q  <= '0;
        end else begin
            state_q    <= state_d;
            rx_valid_q <= 1'b0;
            if (accept) begin
                cmd_q     <= req_cmd_bytes;
                cmd_len_q <= req_cmd_len;
                total_q   <= req_total;
                idx_q     <= '0;
                snap_i_q  <= '0;
            end
            if (state_q == ST_XFER) begin
                idx_q <= idx_q + 1'b1;
                if (want_get) begin
                    rx_byte_q  <= bus_rdata;
                    rx_valid_q <= 1'b1;
                end
            end
            if (state_q == ST_SNAP) begin
                snap_q[snap_i_q*8 +: 8] <= bus_rdata;
                snap_i_q <= snap_i_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_addr  = OFS_MAIN;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        done      = 1'b0;
        err       = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_POLL: begin
                bus_rd   = 1'b1;
                bus_addr = OFS_MAIN;
            end
            ST_XFER: begin
                bus_addr = OFS_DATA;
                if (want_get) begin
                    bus_rd = 1'b1;
                end else begin
                    bus_wr    = 1'b1;
                    bus_wdata = tx_sel;
                end
            end
            ST_SNAP: begin
                bus_rd   = 1'b1;
                bus_addr = snap_offset(snap_i_q);
            end
            ST_FINISH: done = 1'b1;
            ST_FAIL:   err  = 1'b1;
            default: ;
        endcase
    end

    assign fail_idx = idx_q;
    assign rx_valid = rx_valid_q;
    assign rx_byte  = rx_byte_q;
    assign dbg_snap = snap_q;

endmodule

// File: rtl/fdh_xfer_master_chk.sv
module fdh_xfer_master_chk
    import fdh_pkg::*;
#(
    parameter int CLK_HZ     = 1_000_000,
    parameter int SPACING_US = 50,
    parameter int MAX_POLLS  = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       rx_valid,
    input logic [2:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_rdata
);
    localparam int SPACING_CYC = CLK_HZ / 1_000_000 * SPACING_US;
    localparam int GW = $clog2(SPACING_CYC + 2);
    localparam int PW = $clog2(MAX_POLLS + 2);

    logic stat_rd, data_acc, clr;
    logic [GW-1:0] gap_q;
    logic [PW-1:0] polls_q;
    logic fail_pend_q;

    assign stat_rd  = bus_rd && (bus_addr == OFS_MAIN);
    assign data_acc = (bus_rd || bus_wr) && (bus_addr == OFS_DATA);
    assign clr      = data_acc || (bus_rd && bus_addr == OFS_STAT_A) || !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            polls_q     <= '0;
            fail_pend_q <= 1'b0;
        end else begin
            if (stat_rd) gap_q <= GW'(1);
            else if (gap_q != GW'(SPACING_CYC + 1)) gap_q <= gap_q + 1'b1;
            if (stat_rd) begin
                fail_pend_q <= 1'b1;
                if (polls_q != PW'(MAX_POLLS + 1)) polls_q <= polls_q + 1'b1;
            end else if (clr) begin
                fail_pend_q <= 1'b0;
                polls_q     <= '0;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_rd && !bus_wr));

    p_write_after_good_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA) |->
        $past(bus_rd && bus_addr == OFS_MAIN && bus_rdata[MS_READY_BIT] && !bus_rdata[MS_DIR_BIT]));

    p_read_after_good_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DATA) |->
        $past(bus_rd && bus_addr == OFS_MAIN && bus_rdata[MS_READY_BIT] && bus_rdata[MS_DIR_BIT]));

    p_rx_after_data_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bus_rd && bus_addr == OFS_DATA));

    p_poll_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && fail_pend_q) |-> (gap_q == GW'(SPACING_CYC)));

    p_poll_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= PW'(MAX_POLLS));

    p_err_after_snapshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(bus_rd && bus_addr == OFS_DIN));

    p_outcome_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> busy);

    p_outcome_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !busy);

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

endmodule

bind fdh_xfer_master fdh_xfer_master_chk #(
    .CLK_HZ     (CLK_HZ),
    .SPACING_US (SPACING_US),
    .MAX_POLLS  (MAX_POLLS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rx_valid  (rx_valid),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata)
);

// File: tb/fdh_xfer_master_tb_top.sv
module fdh_xfer_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int SPACING_US = 50;
    localparam int MAXP       = 5;
    localparam int MAXC       = 9;
    localparam int MAXR       = 7;
    localparam int SPC        = CLK_HZ / 1_000_000 * SPACING_US;
    localparam int CLW        = $clog2(MAXC + 1);
    localparam int RLW        = $clog2(MAXR + 1);
    localparam int IW         = $clog2(MAXC + MAXR + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic [CLW-1:0] req_cmd_len = '0;
    logic [RLW-1:0] req_res_len = '0;
    logic [MAXC*8-1:0] req_cmd_bytes = '0;
    logic busy, done, err, rx_valid, bus_rd, bus_wr;
    logic [IW-1:0] fail_idx;
    logic [7:0] rx_byte, bus_wdata, bus_rdata;
    logic [39:0] dbg_snap;
    logic [2:0] bus_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdh_xfer_master #(
        .CLK_HZ(CLK_HZ), .SPACING_US(SPACING_US), .MAX_POLLS(MAXP),
        .MAX_CMD(MAXC), .MAX_RES(MAXR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start),
        .req_cmd_len(req_cmd_len), .req_res_len(req_res_len),
        .req_cmd_bytes(req_cmd_bytes), .busy(busy), .done(done), .err(err),
        .fail_idx(fail_idx), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .dbg_snap(dbg_snap), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stimulus set up by the test sequence, read by the controller model
    int         stall [0:16];
    logic [7:0] cmdb  [0:MAXC-1];
    logic [7:0] resb  [0:MAXR-1];
    int         cur_cl = 0;
    bit         clr_model = 1'b0;

    // controller model state
    int         m_pos, m_pc, n_wr, n_rdd, n_any, n_rx, done_cnt, err_cnt;
    int         gap_viol, poll_viol, cyc, last_st_cyc, last_acc_cyc, done_cyc;
    logic [7:0] wlog  [0:16];
    logic [7:0] rxlog [0:16];
    logic [2:0] ring  [0:4];

    function automatic logic [7:0] status_of(int pos, int pc, int cl, int st);
        logic dir;
        dir = (pos >= cl);
        if (pc < st) return (pc % 2 == 1) ? {1'b1, ~dir, 6'b0} : {1'b0, dir, 6'b0};
        return {1'b1, dir, 6'b0};
    endfunction

    always_comb begin
        int ri;
        ri = m_pos - cur_cl;
        case (bus_addr)
            3'd0: bus_rdata = 8'h11;
            3'd1: bus_rdata = 8'h22;
            3'd2: bus_rdata = 8'h33;
            3'd7: bus_rdata = 8'h77;
            3'd4: bus_rdata = status_of(m_pos, m_pc, cur_cl, stall[m_pos > 16 ? 16 : m_pos]);
            3'd5: bus_rdata = (ri >= 0 && ri < MAXR) ? resb[ri] : 8'h00;
            default: bus_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_model) begin
            m_pos <= 0; m_pc <= 0; n_wr <= 0; n_rdd <= 0; n_any <= 0; n_rx <= 0;
            done_cnt <= 0; err_cnt <= 0; gap_viol <= 0; poll_viol <= 0;
            last_acc_cyc <= 0; done_cyc <= 0; last_st_cyc <= 0;
        end else begin
            if (bus_rd || bus_wr) n_any <= n_any + 1;
            if (bus_rd) begin
                ring[0] <= ring[1]; ring[1] <= ring[2]; ring[2] <= ring[3];
                ring[3] <= ring[4]; ring[4] <= bus_addr;
            end
            if (bus_rd && bus_addr == 3'd4) begin
                if (m_pc > 0 && m_pc < MAXP && (cyc - last_st_cyc) != SPC) gap_viol <= gap_viol + 1;
                if (m_pc > MAXP) poll_viol <= poll_viol + 1;
                last_st_cyc <= cyc;
                m_pc <= m_pc + 1;
            end
            if ((bus_rd || bus_wr) && bus_addr == 3'd5) begin
                if (bus_wr) begin
                    wlog[m_pos > 16 ? 16 : m_pos] <= bus_wdata;
                    n_wr <= n_wr + 1;
                end else begin
                    n_rdd <= n_rdd + 1;
                end
                m_pos <= m_pos + 1;
                m_pc <= 0;
                last_acc_cyc <= cyc;
            end
            if (rx_valid) begin
                rxlog[n_rx > 16 ? 16 : n_rx] <= rx_byte;
                n_rx <= n_rx + 1;
            end
            if (done) begin
                done_cnt <= done_cnt + 1;
                done_cyc <= cyc;
            end
            if (err) err_cnt <= err_cnt + 1;
        end
    end

    task automatic run_req(input int cl, input int rl, input bit poke);
        int total, fk, exp_wr, exp_rd, n;
        bit saw_done, saw_err;
        logic [IW-1:0] fidx;
        logic [39:0] snap;
        logic [7:0] st_exp;
        total = cl + rl;
        fk = -1;
        for (int k = total - 1; k >= 0; k--) if (stall[k] >= MAXP) fk = k;
        cur_cl = cl;
        for (int i = 0; i < MAXC; i++) req_cmd_bytes[i*8 +: 8] = cmdb[i];
        @(negedge clk); clr_model = 1'b1;
        @(negedge clk); clr_model = 1'b0;
        req_start = 1'b1; req_cmd_len = CLW'(cl); req_res_len = RLW'(rl);
        @(negedge clk); req_start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", busy, 1);
        saw_done = 0; saw_err = 0; fidx = '0; snap = '0; n = 0;
        while (!saw_done && !saw_err && n < 6000) begin
            if (done) saw_done = 1;
            if (err) begin saw_err = 1; fidx = fail_idx; snap = dbg_snap; end
            if (!saw_done && !saw_err) begin
                if (poke && n == 2) begin
                    req_start = 1'b1; req_cmd_len = CLW'(1); req_res_len = RLW'(1);
                end else begin
                    req_start = 1'b0;
                end
                @(negedge clk);
                n++;
            end
        end
        req_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9", "busy after outcome", busy, 0);
        chk(done_cnt + err_cnt == 1, "R9", "outcome pulses", done_cnt + err_cnt, 1);
        chk(saw_err == (fk >= 0), "R7", "timeout outcome", saw_err, fk >= 0);
        exp_wr = (fk < 0) ? cl : ((fk < cl) ? fk : cl);
        exp_rd = (fk < 0) ? rl : ((fk < cl) ? 0 : fk - cl);
        chk(n_wr == exp_wr, "R6", "bytes sent", n_wr, exp_wr);
        chk(n_rdd == exp_rd, "R7", "bytes read", n_rdd, exp_rd);
        for (int i = 0; i < exp_wr; i++)
            chk(wlog[i] == cmdb[i], "R6", "sent byte", wlog[i], cmdb[i]);
        chk(n_rx == exp_rd, "R3", "rx strobes", n_rx, exp_rd);
        for (int i = 0; i < exp_rd && i < n_rx; i++)
            chk(rxlog[i] == resb[i], "R3", "result byte", rxlog[i], resb[i]);
        chk(gap_viol == 0, "R4", "poll spacing violations", gap_viol, 0);
        chk(poll_viol == 0, "R5", "polls beyond limit", poll_viol, 0);
        if (saw_done && total > 0)
            chk(done_cyc == last_acc_cyc + 1, "R6", "done latency", done_cyc - last_acc_cyc, 1);
        if (total == 0)
            chk(n_any == 0, "R10", "bus accesses on empty request", n_any, 0);
        if (saw_err) begin
            chk(fidx == IW'(fk), "R7", "fail index", fidx, fk);
            st_exp = status_of(fk, MAXP, cl, stall[fk]);
            chk(snap == {8'h77, st_exp, 8'h33, 8'h22, 8'h11}, "R8", "snapshot", snap,
                {8'h77, st_exp, 8'h33, 8'h22, 8'h11});
            chk({ring[0], ring[1], ring[2], ring[3], ring[4]} == {3'd0, 3'd1, 3'd2, 3'd4, 3'd7},
                "R8", "snapshot order", {ring[0], ring[1], ring[2], ring[3], ring[4]},
                {3'd0, 3'd1, 3'd2, 3'd4, 3'd7});
        end
    endtask

    task automatic fill(input int st_all);
        for (int i = 0; i <= 16; i++) stall[i] = st_all;
        for (int i = 0; i < MAXC; i++) cmdb[i] = 8'($urandom);
        for (int i = 0; i < MAXR; i++) resb[i] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        fill(0);
        repeat (3) @(negedge clk);
        chk({busy, done, err, rx_valid, bus_rd, bus_wr} == 6'b0, "R1", "outputs in reset",
            {busy, done, err, rx_valid, bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, bus_rd, bus_wr} == 3'b0, "R1", "idle after reset", {busy, bus_rd, bus_wr}, 0);

        fill(0); run_req(0, 0, 0);                    // R10 empty request
        fill(0); run_req(1, 0, 0);                    // R2 single send
        fill(3); run_req(0, 1, 0);                    // R3 single get after stalls
        fill(MAXP - 1); run_req(MAXC, MAXR, 0);       // R5 last allowed poll succeeds
        fill(0); stall[0] = MAXP; run_req(2, 1, 0);   // R7 timeout on first byte
        fill(1); stall[3] = MAXP + 1; run_req(2, 3, 0); // R8 timeout on a result byte
        fill(1); run_req(3, 2, 1);                    // R9 start while busy ignored

        for (int t = 0; t < 30; t++) begin
            int cl, rl, r;
            fill(0);
            cl = $urandom % (MAXC + 1);
            rl = $urandom % (MAXR + 1);
            for (int k = 0; k < cl + rl; k++) begin
                r = $urandom % 16;
                if (r < 9)       stall[k] = 0;
                else if (r < 13) stall[k] = 1 + ($urandom % 2);
                else if (r == 13) stall[k] = MAXP - 1;
                else if (r == 14) stall[k] = MAXP + ($urandom % 2);
                else              stall[k] = 0;
            end
            run_req(cl, rl, (cl + rl) > 3 && (t % 5 == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule